// File: doc/BRIEF.md
# Rising-Edge Booster for a Shared Reset Line

This block decides when a fast pullup transistor may help a wired, open-drain style reset line back up to the supply. Several agents may pull the line low. Once the line has stayed low long enough, the block arms itself. On the next rise it switches the pullup on for a short burst. The burst starts only after the line has crossed a low threshold, and it ends at whichever comes first: the line crossing a high threshold, or a fixed burst time running out. The line still rises through its passive resistor alone. The burst only shortens the slow middle part of the edge, so that a processor watching the line reads it high within its short sampling window.

Two analog comparators provide the threshold results: the line is above the low threshold, and the line is above roughly 85 percent of the supply. Both arrive asynchronously. The block has no analog parts. It drives one enable for the pullup FET and one enable for a pull-down device. The pull-down device lets the system's own reset request take the line low. The minimum low time and the burst length are counted in clock cycles and set by parameters.

Top module: `reset_line_booster`

## Requirements
- R1: While `rstN` is low, and directly after it is released, `pullupEn` is 0.
- R2: `pullLowEn` equals `resetReq` in the same cycle, with no clock delay.
- R3: A low excursion that the synchronized low comparator sees for fewer than `MIN_LOW_TICKS` consecutive cycles does not arm the block, and no pullup burst follows when the line rises.
- R4: Once the synchronized low comparator has read low for at least `MIN_LOW_TICKS` consecutive cycles, the block is armed. A later rise into the window (low comparator 1, high comparator 0) then turns `pullupEn` on. The pullup rises at the third clock edge after that comparator state appears at the inputs, or at the fourth when arming and release fall together.
- R5: A pullup burst ends when the synchronized high comparator reads 1.
- R6: A pullup burst never lasts more than `BURST_TICKS` consecutive cycles. When the high comparator stays 0, the burst lasts exactly `BURST_TICKS` cycles.
- R7: `pullupEn` is 0 in every cycle where `resetReq` is 1. A request that arrives during a burst ends the burst, and the burst does not resume after the request drops. A low pulse driven by the block's own request arms the block in the same way as an external one.
- R8: Each armed low pulse gives at most one burst. The line sagging back into the window after a burst does not start another.
- R9: If the line is pulled low again during a burst, the burst ends. If an armed line jumps straight above the high threshold, the block disarms and no burst follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that counts the low time and the burst |
| rstN | input | 1 | Asynchronous reset, active low |
| lineAboveLo | input | 1 | Asynchronous comparator: line is above the low threshold |
| lineAboveHi | input | 1 | Asynchronous comparator: line is above about 85 percent of the supply |
| resetReq | input | 1 | Request to pull the line low for a local reset |
| pullupEn | output | 1 | Turns on the fast active pullup |
| pullLowEn | output | 1 | Turns on the pull-down device |

## Verification
The hardest case to reach is the one where the low-time qualification and the release land together. The line must stay low for exactly `MIN_LOW_TICKS` synchronized cycles and then rise at once. In that case arming and the window test happen on consecutive edges. The stimulus holds the low comparator at 0 for exactly `MIN_LOW_TICKS` clock cycles, set against the sampling edges, and for one cycle fewer in a separate test. Only the exact-length pulse may give a burst, and that burst must run its full length. A second hard case is a request that interrupts a burst already in progress. That test first arms the block with the block's own request, lets the burst start, and then raises the request in the middle of it.

// File: rtl/rpu_pkg.sv
package rpu_pkg;

  // Edge-tracking state: ARMED and BURST together form the transition-edge flag.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_BURST = 2'd2
  } edgeState_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic burstLoad;  // start the burst timer
    logic burstRun;   // burst timer counts down
  } ctrlStrobes_t;

  // Status from datapath to control.
  typedef struct packed {
    logic loSync;     // synchronized low comparator
    logic hiSync;     // synchronized high comparator
    logic lowMet;     // line low long enough to arm
    logic burstDone;  // burst timer at its last cycle
  } dpStatus_t;

  localparam int NUM_CMP = 2;
  localparam int CMP_LO  = 0;
  localparam int CMP_HI  = 1;

endpackage

// File: rtl/rpu_datapath.sv
module rpu_datapath
  import rpu_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int MIN_LOW_TICKS = 20,
  parameter int BURST_TICKS   = 400
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_CMP-1:0] cmpRaw,
  input  ctrlStrobes_t       strobes,
  output dpStatus_t          status
);

  localparam int LOW_W   = $clog2(MIN_LOW_TICKS + 1);
  localparam int BURST_W = $clog2(BURST_TICKS);
  localparam logic [LOW_W-1:0]   LOW_LIMIT  = LOW_W'(MIN_LOW_TICKS);
  localparam logic [BURST_W-1:0] BURST_LAST = BURST_W'(BURST_TICKS - 1);

  logic [NUM_CMP-1:0] cmpSync;

  // One synchronizer chain per comparator.
  for (genvar g = 0; g < NUM_CMP; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[SYNC_STAGES-2:0], cmpRaw[g]};
    end
    assign cmpSync[g] = chain[SYNC_STAGES-1];
  end

  // Consecutive low-time counter, saturating at the qualification limit.
  logic [LOW_W-1:0] lowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 lowCnt <= '0;
    else if (cmpSync[CMP_LO])  lowCnt <= '0;
    else if (lowCnt != LOW_LIMIT) lowCnt <= lowCnt + 1'b1;
  end

  // Burst length timer.
  logic [BURST_W-1:0] burstCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   burstCnt <= '0;
    else if (strobes.burstLoad)                  burstCnt <= BURST_LAST;
    else if (strobes.burstRun && burstCnt != '0) burstCnt <= burstCnt - 1'b1;
  end

  assign status.loSync    = cmpSync[CMP_LO];
  assign status.hiSync    = cmpSync[CMP_HI];
  assign status.lowMet    = (lowCnt == LOW_LIMIT);
  assign status.burstDone = (burstCnt == '0);

endmodule

// File: rtl/rpu_control.sv
module rpu_control
  import rpu_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  dpStatus_t    status,
  input  logic         resetReq,
  output ctrlStrobes_t strobes,
  output logic         pullupEn
);

  edgeState_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (status.lowMet) stateNext = ST_ARMED;
      end
      ST_ARMED: begin
        if (status.loSync && status.hiSync)                      stateNext = ST_IDLE;
        else if (status.loSync && !resetReq)                     stateNext = ST_BURST;
      end
      ST_BURST: begin
        if (resetReq || !status.loSync || status.hiSync || status.burstDone)
          stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign strobes.burstLoad = (state == ST_ARMED) && (stateNext == ST_BURST);
  assign strobes.burstRun  = (state == ST_BURST);

  // A local reset request always wins over the pullup.
  assign pullupEn = (state == ST_BURST) && !resetReq;

endmodule

// File: rtl/reset_line_booster.sv
module reset_line_booster
  import rpu_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int MIN_LOW_TICKS = 20,
  parameter int BURST_TICKS   = 400
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineAboveLo,
  input  logic lineAboveHi,
  input  logic resetReq,
  output logic pullupEn,
  output logic pullLowEn
);

  ctrlStrobes_t strobes;
  dpStatus_t    status;
  logic [NUM_CMP-1:0] cmpRaw;

  assign cmpRaw[CMP_LO] = lineAboveLo;
  assign cmpRaw[CMP_HI] = lineAboveHi;

  rpu_datapath #(
    .SYNC_STAGES  (SYNC_STAGES),
    .MIN_LOW_TICKS(MIN_LOW_TICKS),
    .BURST_TICKS  (BURST_TICKS)
  ) i_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .cmpRaw (cmpRaw),
    .strobes(strobes),
    .status (status)
  );

  rpu_control i_control (
    .clk     (clk),
    .rstN    (rstN),
    .status  (status),
    .resetReq(resetReq),
    .strobes (strobes),
    .pullupEn(pullupEn)
  );

  assign pullLowEn = resetReq;

endmodule

// File: rtl/rpu_checker.sv
module rpu_checker #(
  parameter int SYNC_STAGES = 2,
  parameter int BURST_TICKS = 400
) (
  input logic clk,
  input logic rstN,
  input logic lineAboveLo,
  input logic lineAboveHi,
  input logic resetReq,
  input logic pullupEn,
  input logic pullLowEn
);

  localparam int RUN_W = $clog2(BURST_TICKS + 1) + 1;

  // Length of the current pullup run, in cycles before this one.
  logic [RUN_W-1:0] runLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         runLen <= '0;
    else if (pullupEn) runLen <= runLen + 1'b1;
    else               runLen <= '0;
  end

  AST_REQ_BLOCKS_PULLUP: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> (!pullupEn && pullLowEn)); // R7

  AST_BURST_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    pullupEn |-> (runLen < RUN_W'(BURST_TICKS))); // R6

  AST_SINGLE_BURST: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pullupEn) |=> !pullupEn); // R8

  if (SYNC_STAGES == 2) begin : g_window
    AST_RISE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pullupEn) |-> ($past(lineAboveLo, 3) && !$past(lineAboveHi, 3))); // R4
  end

endmodule

bind reset_line_booster rpu_checker #(
  .SYNC_STAGES(SYNC_STAGES),
  .BURST_TICKS(BURST_TICKS)
) i_rpu_checker (
  .clk        (clk),
  .rstN       (rstN),
  .lineAboveLo(lineAboveLo),
  .lineAboveHi(lineAboveHi),
  .resetReq   (resetReq),
  .pullupEn   (pullupEn),
  .pullLowEn  (pullLowEn)
);

// File: tb/test_reset_line_booster.sv
`timescale 1ns/1ps
module test_reset_line_booster;

  localparam int MIN_LOW = 8;
  localparam int BURST   = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineAboveLo = 1'b1;
  logic lineAboveHi = 1'b1;
  logic resetReq = 1'b0;
  logic pullupEn, pullLowEn;

  int nCompared = 0;
  int nMismatched = 0;
  int pullCycles = 0;
  int pullRises = 0;
  int overlapCnt = 0;
  logic prevPull = 1'b0;

  always #2.5 clk = ~clk;

  reset_line_booster #(
    .SYNC_STAGES  (2),
    .MIN_LOW_TICKS(MIN_LOW),
    .BURST_TICKS  (BURST)
  ) i_reset_line_booster (
    .clk        (clk),
    .rstN       (rstN),
    .lineAboveLo(lineAboveLo),
    .lineAboveHi(lineAboveHi),
    .resetReq   (resetReq),
    .pullupEn   (pullupEn),
    .pullLowEn  (pullLowEn)
  );

  // Output monitor, sampled away from the rising edge.
  always @(negedge clk) begin
    if (pullupEn) pullCycles++;
    if (pullupEn && !prevPull) pullRises++;
    if (pullupEn && resetReq) overlapCnt++;
    prevPull = pullupEn;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nCompared++;
    if (!ok) begin
      nMismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic clearCounts();
    pullCycles = 0; pullRises = 0; overlapCnt = 0;
  endtask

  task automatic waitRise(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 20 && !seen; i++) begin
      cyc(1);
      if (pullupEn) seen = 1'b1;
    end
  endtask

  task automatic settleHigh();
    lineAboveLo = 1'b1; lineAboveHi = 1'b1; resetReq = 1'b0;
    cyc(BURST + 10);
  endtask

  task automatic t_reset();
    check(pullupEn == 1'b0, "R1", pullupEn, 0);
    check(pullLowEn == 1'b0, "R1", pullLowEn, 0);
    rstN = 1'b1;
    cyc(2);
    check(pullupEn == 1'b0, "R1", pullupEn, 0);
  endtask

  task automatic t_pullLow();
    resetReq = 1'b1; #1;
    check(pullLowEn == 1'b1, "R2", pullLowEn, 1);
    resetReq = 1'b0; #1;
    check(pullLowEn == 1'b0, "R2", pullLowEn, 0);
    cyc(1);
  endtask

  task automatic t_shortLow();
    clearCounts();
    lineAboveLo = 1'b0; lineAboveHi = 1'b0;
    cyc(MIN_LOW - 1);
    lineAboveLo = 1'b1;
    cyc(BURST + 10);
    check(pullRises == 0, "R3", pullRises, 0);
    settleHigh();
  endtask

  task automatic t_exactLowFullBurst();
    clearCounts();
    lineAboveLo = 1'b0; lineAboveHi = 1'b0;
    cyc(MIN_LOW);
    lineAboveLo = 1'b1;
    cyc(3);
    check(pullupEn == 1'b0, "R4", pullupEn, 0);
    cyc(1);
    check(pullupEn == 1'b1, "R4", pullupEn, 1);
    cyc(BURST + 10);
    check(pullRises == 1, "R4", pullRises, 1);
    check(pullCycles == BURST, "R6", pullCycles, BURST);
    settleHigh();
  endtask

  task automatic t_highEnds();
    bit seen;
    clearCounts();
    lineAboveLo = 1'b0; lineAboveHi = 1'b0;
    cyc(MIN_LOW + 5);
    lineAboveLo = 1'b1;
    waitRise(seen);
    check(seen, "R4", seen, 1);
    cyc(3);
    lineAboveHi = 1'b1;
    cyc(3);
    check(pullupEn == 1'b0, "R5", pullupEn, 0);
    check(pullCycles >= 4 && pullCycles <= 8, "R5", pullCycles, 7);
    // Line sags back into the window: no new burst.
    clearCounts();
    lineAboveHi = 1'b0;
    cyc(BURST + 10);
    check(pullRises == 0, "R8", pullRises, 0);
    settleHigh();
  endtask

  task automatic t_lowAgain();
    bit seen;
    clearCounts();
    lineAboveLo = 1'b0; lineAboveHi = 1'b0;
    cyc(MIN_LOW + 5);
    lineAboveLo = 1'b1;
    waitRise(seen);
    check(seen, "R9", seen, 1);
    cyc(4);
    lineAboveLo = 1'b0;
    cyc(3);
    check(pullupEn == 1'b0, "R9", pullupEn, 0);
    check(pullCycles < BURST, "R9", pullCycles, 8);
    // Re-armed by this long low: jump straight above the high threshold.
    cyc(MIN_LOW + 5);
    clearCounts();
    lineAboveLo = 1'b1; lineAboveHi = 1'b1;
    cyc(BURST + 10);
    check(pullRises == 0, "R9", pullRises, 0);
    // Then sag into the window: disarmed, so still no burst.
    lineAboveHi = 1'b0;
    cyc(BURST + 10);
    check(pullRises == 0, "R9", pullRises, 0);
    settleHigh();
  endtask

  task automatic t_ownReset();
    bit seen;
    clearCounts();
    resetReq = 1'b1;
    lineAboveLo = 1'b0; lineAboveHi = 1'b0;
    cyc(MIN_LOW + 5);
    check(pullLowEn == 1'b1, "R7", pullLowEn, 1);
    check(pullupEn == 1'b0, "R7", pullupEn, 0);
    resetReq = 1'b0; lineAboveLo = 1'b1;
    waitRise(seen);
    check(seen, "R7", seen, 1);
    cyc(3);
    resetReq = 1'b1; #1;
    check(pullupEn == 1'b0, "R7", pullupEn, 0);
    cyc(4);
    resetReq = 1'b0;
    cyc(BURST + 10);
    check(pullRises == 1, "R7", pullRises, 1);
    check(overlapCnt == 0, "R7", overlapCnt, 0);
    settleHigh();
  endtask

  initial begin
    cyc(3);
    t_reset();
    cyc(4);
    t_pullLow();
    t_shortLow();
    t_exactLowFullBurst();
    t_highEnds();
    t_lowAgain();
    t_ownReset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end

  initial begin
    #500000;
    nCompared++;
    nMismatched++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end

endmodule